// File: doc/BRIEF.md
# Handshaked Serial Result Transmitter

This block sends a finished conversion result to an external processor one bit at a time. The sequencer loads a 23-bit magnitude and a polarity flag with a one-cycle start strobe. The block then lowers its data-valid strobe and places the first bit on its data output. The processor reads the bit and returns one pulse on the serial clock, low and then high. After each pulse the block raises data-valid for one system clock, moves the next bit onto the data line, and lowers data-valid again. The polarity bit is the last of the 24 bits. After it has been taken, data-valid stays high until the next result is loaded.

If the processor leaves the first bit unclaimed for a programmable number of system clocks, the block drops the word, raises data-valid and tells the sequencer to begin a new conversion. A low-active chip select enables the pad drivers for the data-valid and data lines. While the chip is deselected, serial clock activity is ignored, so several transmitters can share one set of processor lines.

Top module: `hs_result_tx`

## Requirements
- R1: After reset, `dv_o` is 1, `dout_o` is 0, and `done_o` and `timeout_o` are 0.
- R2: A `start_i` pulse while idle makes `dv_o` 0 in the next cycle, with bit 22 of `count_i` on `dout_o` in that same cycle.
- R3: The bits go out in this order: `count_i` bit 22 down to bit 0, then the polarity bit (`sign_i`, 1 = positive) as the 24th bit. The word is captured at start, so later changes of `count_i` or `sign_i` do not alter it.
- R4: A serial clock pulse is a falling edge followed by a rising edge on `sclk_i`. When the rising edge is detected, `dv_o` goes to 1 for one cycle and the next bit appears on `dout_o`. `dv_o` then returns to 0. While `dv_o` stays 0, `dout_o` does not change.
- R5: A rising edge on `sclk_i` that no falling edge has preceded during the current bit does not advance the transfer. The processor keeps `sclk_i` high when idle.
- R6: The pulse that takes the 24th bit raises `dv_o` and gives a one-cycle `done_o` pulse. `dv_o` then stays 1 until the next start.
- R7: If the first bit gets no complete pulse within `TMO_CYC` cycles after `dv_o` falls, `timeout_o` pulses for one cycle and `dv_o` returns to 1. `done_o` does not pulse for that word.
- R8: The timeout applies only to the first bit. Once one bit has been taken, the transfer waits for as long as the processor needs.
- R9: While `cs_n_i` is 1, `pin_oe_o` is 0 and serial clock pulses do not advance the transfer. When the chip is selected again, the same bit is still offered.
- R10: A `start_i` pulse during a transfer is ignored, and the word in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe from the sequencer: result ready |
| count_i | input | 23 | Conversion magnitude, captured at start |
| sign_i | input | 1 | Polarity, 1 = positive, captured at start |
| cs_n_i | input | 1 | Chip select, low active |
| sclk_i | input | 1 | Serial clock from the processor, asynchronous |
| dv_o | output | 1 | Data-valid strobe, low while a bit is offered |
| dout_o | output | 1 | Serial data bit |
| pin_oe_o | output | 1 | Pad drive enable for `dv_o` and `dout_o` (0 = high impedance) |
| done_o | output | 1 | One-cycle pulse: all 24 bits taken |
| timeout_o | output | 1 | One-cycle pulse: first bit abandoned |

## Verification
A bit counter that is off by one shows on the pins within one handshake. The wrong bit appears on `dout_o` straight after a pulse, or `done_o` fires one pulse early or late. A broken edge tracker shows within a few cycles of a pulse as a missed or doubled advance. A timer that runs when it should not, or never runs, shows only after `TMO_CYC` cycles. The bench therefore waits past the limit on both the first bit and a later bit.

// File: rtl/hs_tx_pkg.sv
// Shared types for the handshaked serial result transmitter.
package hs_tx_pkg;
    // Transfer controller states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,  // no word pending, strobe high
        ST_WFALL = 2'd1, // bit offered, waiting for clock to fall
        ST_WRISE = 2'd2, // bit offered, waiting for clock to rise
        ST_GAP  = 2'd3   // strobe high for one cycle between bits
    } tx_state_e;
endpackage

// File: rtl/hs_tx_sync.sv
// Two-flop synchroniser for the processor's serial clock plus edge detect.
// Assumes din is asynchronous to clk and pulses last at least two clocks
// per level. Edges are masked when en is low (chip not selected).
module hs_tx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    // Resynchronise and keep one previous sample; idle level is high
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge strobes, gated by selection
    always_comb begin
        rise = en && sync_q && !prev_q;
        fall = en && !sync_q && prev_q;
    end
endmodule

// File: rtl/hs_tx_shifter.sv
// Holds the captured word and counts bits sent. The MSB is always the
// bit on offer. Assumes load and shift are never high together.
module hs_tx_shifter #(
    parameter int WORD_W = 24,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift,
    output logic              msb,
    output logic [IDX_W-1:0]  idx,
    output logic              last
);
    logic [WORD_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;

    // Capture on load, move up one place per accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            idx_q <= '0;
        end else if (load) begin
            sh_q  <= load_word;
            idx_q <= '0;
        end else if (shift) begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            idx_q <= idx_q + 1'b1;
        end
    end

    assign msb  = sh_q[WORD_W-1];
    assign idx  = idx_q;
    assign last = (idx_q == IDX_W'(WORD_W-1));
endmodule

// File: rtl/hs_tx_timer.sv
// First-bit timeout counter. Counts while run is high, clears otherwise,
// flags expiry in the cycle the count reaches LIMIT-1.
module hs_tx_timer #(
    parameter int LIMIT = 275000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    logic [CW-1:0] cnt_q;

    // Count system clocks spent waiting on the first bit
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/hs_result_tx.sv
// Handshaked serial result transmitter. Sends {count, sign} MSB first,
// one bit per externally supplied clock pulse, with data-valid low while
// a bit is on offer. Assumes cs_n_i is quasi-static around transfers and
// that the processor idles sclk_i high.
module hs_result_tx #(
    parameter int CNT_W   = 23,
    parameter int TMO_CYC = 275000,
    localparam int WORD_W = CNT_W + 1,
    localparam int IDX_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             sign_i,
    input  logic             cs_n_i,
    input  logic             sclk_i,
    output logic             dv_o,
    output logic             dout_o,
    output logic             pin_oe_o,
    output logic             done_o,
    output logic             timeout_o
);
    import hs_tx_pkg::*;

    tx_state_e        st_q, st_d;
    logic             sclk_rise, sclk_fall;
    logic             load, shift, last, tmo_hit, busy, tmo_run;
    logic [IDX_W-1:0] idx;
    logic             done_q, tmo_q;

    hs_tx_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (sclk_i),
        .en   (!cs_n_i),
        .rise (sclk_rise),
        .fall (sclk_fall)
    );

    hs_tx_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_word({count_i, sign_i}),
        .shift    (shift),
        .msb      (dout_o),
        .idx      (idx),
        .last     (last)
    );

    assign tmo_run = (st_q == ST_WFALL || st_q == ST_WRISE) && (idx == '0);

    hs_tx_timer #(.LIMIT(TMO_CYC)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (tmo_run),
        .expired(tmo_hit)
    );

    // Next-state and control strobes of the handshake
    always_comb begin
        st_d  = st_q;
        load  = 1'b0;
        shift = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start_i) begin
                load = 1'b1;
                st_d = ST_WFALL;
            end
            ST_WFALL: begin
                if (sclk_fall)    st_d = ST_WRISE;
                else if (tmo_hit) st_d = ST_IDLE;
            end
            ST_WRISE: begin
                if (sclk_rise) begin
                    shift = !last;
                    st_d  = last ? ST_IDLE : ST_GAP;
                end else if (tmo_hit) begin
                    st_d = ST_IDLE;
                end
            end
            ST_GAP: st_d = ST_WFALL;
            default: st_d = ST_IDLE;
        endcase
    end

    // State register and one-cycle completion strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
        end else begin
            st_q   <= st_d;
            done_q <= (st_q == ST_WRISE) && sclk_rise && last;
            tmo_q  <= tmo_run && tmo_hit
                      && !((st_q == ST_WFALL) && sclk_fall)
                      && !((st_q == ST_WRISE) && sclk_rise);
        end
    end

    assign busy      = (st_q != ST_IDLE);
    assign dv_o      = !(st_q == ST_WFALL || st_q == ST_WRISE);
    assign pin_oe_o  = !cs_n_i;
    assign done_o    = done_q;
    assign timeout_o = tmo_q;
endmodule

// File: rtl/hs_result_tx_chk.sv
// Protocol checker for hs_result_tx, attached by bind below.
module hs_result_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic dv_o,
    input logic dout_o,
    input logic done_o,
    input logic timeout_o,
    input logic busy,
    input logic sclk_rise
);
    AST_START_DROPS_DV: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy) |=> !dv_o); // R2
    AST_DOUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!dv_o && $past(!dv_o)) |-> $stable(dout_o)); // R4
    AST_DONE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(sclk_rise) && dv_o)); // R6
    AST_TMO_RAISES_DV: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (dv_o && !busy)); // R7
    AST_SINGLE_END: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && timeout_o)); // R7
endmodule

bind hs_result_tx hs_result_tx_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .dv_o     (dv_o),
    .dout_o   (dout_o),
    .done_o   (done_o),
    .timeout_o(timeout_o),
    .busy     (busy),
    .sclk_rise(sclk_rise)
);

// File: tb/sim_hs_result_tx.sv
// Bench for hs_result_tx: directed corners plus seeded random words.
module sim_hs_result_tx;
    localparam int CNT_W = 23;
    localparam int TMO   = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [CNT_W-1:0] count_i = '0;
    logic sign_i = 1'b0;
    logic cs_n_i = 1'b0;
    logic sclk_i = 1'b1;
    logic dv_o, dout_o, pin_oe_o, done_o, timeout_o;

    int n_chk = 0, n_bad = 0, n_done = 0, n_tmo = 0;

    always #10 clk = ~clk;

    hs_result_tx #(.CNT_W(CNT_W), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .sign_i(sign_i), .cs_n_i(cs_n_i), .sclk_i(sclk_i), .dv_o(dv_o),
        .dout_o(dout_o), .pin_oe_o(pin_oe_o), .done_o(done_o),
        .timeout_o(timeout_o)
    );

    // Count completion strobes away from the active edge
    always @(negedge clk) begin
        if (done_o)    n_done++;
        if (timeout_o) n_tmo++;
    end

    function automatic logic [CNT_W:0] exp_word(input logic [CNT_W-1:0] c, input logic s);
        return {c, s};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic kick(input logic [CNT_W-1:0] c, input logic s);
        count_i = c; sign_i = s; start_i = 1'b1;
        clks(1);
        start_i = 1'b0;
        count_i = ~c; sign_i = ~s; // later changes must not matter (R3)
    endtask

    task automatic pulse();
        sclk_i = 1'b0; clks(4);
        sclk_i = 1'b1; clks(5);
    endtask

    // Take a full word, checking each bit while offered
    task automatic take_word(input logic [CNT_W:0] w, input int first);
        for (int i = first; i <= CNT_W; i++) begin
            check("R4 dv low while bit offered", dv_o, 0);
            check("R3 bit value", dout_o, w[CNT_W-i]);
            pulse();
        end
    endtask

    initial begin : watchdog
        clks(150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        logic [CNT_W:0] w;
        int d0;
        void'($urandom(32'd2024));
        clks(3);
        check("R1 dv reset", dv_o, 1);
        check("R1 dout reset", dout_o, 0);
        check("R1 done reset", done_o, 0);
        check("R1 timeout reset", timeout_o, 0);
        rst_n = 1'b1;
        clks(2);

        // Directed: alternating pattern, positive
        w = exp_word(23'h555555, 1'b1);
        kick(23'h555555, 1'b1);
        check("R2 dv low after start", dv_o, 0);
        check("R2 msb on dout", dout_o, w[CNT_W]);
        d0 = n_done;
        take_word(w, 0);
        check("R6 dv high after last", dv_o, 1);
        check("R6 one done pulse", n_done - d0, 1);
        clks(20);
        check("R6 dv stays high", dv_o, 1);

        // R5: rise with no preceding fall does not advance
        sclk_i = 1'b0; clks(4);
        w = exp_word(23'h400000, 1'b0);
        kick(23'h400000, 1'b0);
        sclk_i = 1'b1; clks(6);
        check("R5 no advance dv", dv_o, 0);
        check("R5 no advance dout", dout_o, 1);
        take_word(w, 0);

        // R7: timeout on first bit
        d0 = n_done;
        kick(23'h7fffff, 1'b1);
        clks(TMO - 10);
        check("R7 still waiting", dv_o, 0);
        check("R7 no early timeout", n_tmo, 0);
        clks(20);
        check("R7 timeout pulse", n_tmo, 1);
        check("R7 dv high", dv_o, 1);
        check("R7 no done", n_done - d0, 0);

        // R8, R9, R10 within one word
        w = exp_word(23'h2abcde, 1'b0);
        kick(23'h2abcde, 1'b0);
        take_word(w, 0);  // consumes whole word; redo with pauses below
        w = exp_word(23'h13579b, 1'b1);
        d0 = n_done;
        kick(23'h13579b, 1'b1);
        check("R3 bit0", dout_o, w[CNT_W]);
        pulse();
        clks(2 * TMO);
        check("R8 no timeout later bit", n_tmo, 1);
        check("R8 still offered", dv_o, 0);
        cs_n_i = 1'b1; clks(1);
        check("R9 oe off", pin_oe_o, 0);
        pulse(); pulse();
        cs_n_i = 1'b0; clks(1);
        check("R9 oe on", pin_oe_o, 1);
        check("R9 same bit", dout_o, w[CNT_W-1]);
        count_i = 23'h0; sign_i = 1'b0; start_i = 1'b1; clks(1); start_i = 1'b0;
        check("R10 start ignored", dout_o, w[CNT_W-1]);
        take_word(w, 1);
        check("R6 done after paused word", n_done - d0, 1);

        // Random words
        for (int k = 0; k < 8; k++) begin
            logic [CNT_W-1:0] c;
            logic s;
            c = CNT_W'($urandom);
            s = 1'($urandom);
            w = exp_word(c, s);
            d0 = n_done;
            kick(c, s);
            take_word(w, 0);
            check("R6 random done", n_done - d0, 1);
            clks(int'($urandom_range(1, 10)));
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule